// File: doc/BRIEF.md
# Microcontroller Operating Mode Controller

This block keeps track of the operating mode of a small 8-bit microcontroller and produces the clock-gating and power-domain enables that follow from that mode. It watches the power-on reset, a reset requested by the debug port, the level of a mode-select pin, the background triggers (a command from the debug port, a background instruction and two breakpoint sources), the wait and stop instructions together with a stop-depth selector, a wake event, and a debug "go" command.

Six modes exist: Run, a debug-halt Background mode, Wait, and three stop depths. Deeper stop levels retain less. Stop depth 3 keeps registers and RAM. Stop depth 2 keeps only RAM. Stop depth 1 keeps nothing. A reset-style restart samples the mode-select pin. If the pin is high the block enters Run and raises a one-cycle strobe that tells the core to fetch the reset vector. If the pin is low the block halts in Background mode. The CPU core, the debug serial link and the analog power circuits sit outside this block.

Top module: `opmode_ctrl`

## Requirements
- R1: While `rst` is high, `mode_o` is 0 (Run code), all five enables are low and `vec_fetch` is low.
- R2: After a restart with `mode_pin` sampled high, `mode_o` becomes 0 (Run) and `vec_fetch` is high for exactly that first Run cycle, with `vec_addr` = 0xFFFE. Otherwise `vec_addr` is 0.
- R3: The pin is sampled in the last cycle of `rst`, or in the cycle where `dbg_force_rst` is high (this is accepted from any mode). If the sampled level is low, the cycle after the restart shows `mode_o` = 1 (Background) and `vec_fetch` stays low.
- R4: In Run, a pulse on `dbg_bg_cmd`, `bg_instr`, `brk_ctl_hit` or `brk_mon_hit` moves the block to Background one cycle later. A background trigger has priority over a wait or stop instruction arriving in the same cycle.
- R5: In Background, only `dbg_go` (which returns to Run without a vector fetch) or `dbg_force_rst` changes the mode. All other strobes are ignored.
- R6: `wait_instr` in Run gives `mode_o` = 2 (Wait). In Wait the CPU clock is off, while the bus clock, full regulation, RAM retention and register retention are on.
- R7: `stop_instr` in Run with `stop_depth` equal to 1, 2 or 3 gives `mode_o` = 3, 4 or 5. A stop with `stop_depth` = 0 is ignored. The CPU and bus clocks are off in every stop mode.
- R8: Retention per stop depth, as {reg_full, ram_ret, reg_ret}: depth 1 = 000, depth 2 = 010, depth 3 = 011.
- R9: `wake` in Wait or stop depth 3 returns to Run one cycle later with no vector fetch. `wake` in Run and `stop_instr` in Wait are ignored.
- R10: `wake` in stop depth 1 or 2 starts a restart cycle. In that cycle the stop code is held. The next cycle follows R2/R3 using the pin level sampled with the wake, and all enables are low for the first cycle after the restart.
- R11: The enables are registered and follow the mode one cycle after `mode_o` changes. In Run and Background the bus clock, regulation and both retentions are on, and the CPU clock is on only in Run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| dbg_force_rst | input | 1 | Reset request from the debug port |
| mode_pin | input | 1 | Level of the mode-select pin |
| dbg_bg_cmd | input | 1 | Background command from the debug port |
| bg_instr | input | 1 | Background instruction strobe |
| brk_ctl_hit | input | 1 | Debug-controller breakpoint strobe |
| brk_mon_hit | input | 1 | Debug-monitor breakpoint strobe |
| wait_instr | input | 1 | Wait instruction strobe |
| stop_instr | input | 1 | Stop instruction strobe |
| stop_depth | input | DEPTH_W | Requested stop depth (1..3) |
| wake | input | 1 | Wake or interrupt event |
| dbg_go | input | 1 | Debug command to resume execution |
| mode_o | output | 3 | Current mode code |
| cpu_clk_en | output | 1 | CPU clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| reg_full_en | output | 1 | Full voltage regulation enable |
| ram_ret_en | output | 1 | RAM retention enable |
| regs_ret_en | output | 1 | Register retention enable |
| vec_fetch | output | 1 | One-cycle reset-vector fetch strobe |
| vec_addr | output | VEC_W | Vector address during the strobe, else 0 |

## Verification
Each of the four background triggers is applied alone from Run, and every strobe is applied alone in Background. This separates a missing entry cause from a leak that lets Background be left without `dbg_go`. Each stop depth is entered, its enables are compared against the retention table, and it is then woken. The three depths differ only in enables and in whether a restart cycle with a vector strobe happens, so an exchanged depth shows up. Restarts are run with the pin both high and low, through reset, through a debug-forced reset and through a depth-1 wake, so that pin sampling is checked separately on each path. Simultaneous background and wait/stop strobes check the trigger priority.

// File: rtl/opmode_pkg.sv
package opmode_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    M_RUN   = 3'd0,
    M_BKG   = 3'd1,
    M_WAIT  = 3'd2,
    M_STOP1 = 3'd3,
    M_STOP2 = 3'd4,
    M_STOP3 = 3'd5
  } mode_e;

  typedef struct packed {
    logic cpu;
    logic bus;
    logic reg_full;
    logic ram_ret;
    logic reg_ret;
  } pwr_en_t;

  typedef struct packed {
    logic force_rst;
    logic go;
    logic wake;
    logic stop_i;
    logic wait_i;
    logic brk_mon;
    logic brk_ctl;
    logic bg_instr;
    logic bg_cmd;
  } evt_t;

  // Enables implied by a mode; a pending restart gates everything off.
  function automatic pwr_en_t mode_enables(mode_e m, logic restart);
    pwr_en_t e;
    e = '0;
    if (!restart) begin
      unique case (m)
        M_RUN:   e = '{cpu: 1'b1, bus: 1'b1, reg_full: 1'b1, ram_ret: 1'b1, reg_ret: 1'b1};
        M_BKG,
        M_WAIT:  e = '{cpu: 1'b0, bus: 1'b1, reg_full: 1'b1, ram_ret: 1'b1, reg_ret: 1'b1};
        M_STOP1: e = '0;
        M_STOP2: e = '{cpu: 1'b0, bus: 1'b0, reg_full: 1'b0, ram_ret: 1'b1, reg_ret: 1'b0};
        M_STOP3: e = '{cpu: 1'b0, bus: 1'b0, reg_full: 1'b0, ram_ret: 1'b1, reg_ret: 1'b1};
        default: e = '0;
      endcase
    end
    return e;
  endfunction
endpackage

// File: rtl/opmode_next.sv
module opmode_next
  import opmode_pkg::*;
#(
  parameter int DEPTH_W = 2
) (
  input  mode_e              mode_q,
  input  logic               restart_q,
  input  logic               pin_q,
  input  logic               mode_pin,
  input  evt_t               ev,
  input  logic [DEPTH_W-1:0] stop_depth,
  output mode_e              mode_d,
  output logic               restart_d,
  output logic               pin_d,
  output logic               vec_d
);
  logic bg_any;
  assign bg_any = ev.bg_cmd | ev.bg_instr | ev.brk_ctl | ev.brk_mon;

  always_comb begin
    mode_d    = mode_q;
    restart_d = 1'b0;
    pin_d     = pin_q;
    vec_d     = 1'b0;
    if (ev.force_rst) begin
      restart_d = 1'b1;
      pin_d     = mode_pin;
    end else if (restart_q) begin
      mode_d = pin_q ? M_RUN : M_BKG;
      vec_d  = pin_q;
    end else begin
      unique case (mode_q)
        M_RUN: begin
          if (bg_any)
            mode_d = M_BKG;
          else if (ev.wait_i)
            mode_d = M_WAIT;
          else if (ev.stop_i) begin
            if (stop_depth == DEPTH_W'(1))      mode_d = M_STOP1;
            else if (stop_depth == DEPTH_W'(2)) mode_d = M_STOP2;
            else if (stop_depth == DEPTH_W'(3)) mode_d = M_STOP3;
          end
        end
        M_BKG:   if (ev.go) mode_d = M_RUN;
        M_WAIT,
        M_STOP3: if (ev.wake) mode_d = M_RUN;
        M_STOP1,
        M_STOP2: if (ev.wake) begin
          restart_d = 1'b1;
          pin_d     = mode_pin;
        end
        default: mode_d = M_RUN;
      endcase
    end
  end
endmodule

// File: rtl/opmode_state.sv
module opmode_state
  import opmode_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  mode_pin,
  input  mode_e mode_d,
  input  logic  restart_d,
  input  logic  pin_d,
  input  logic  vec_d,
  output mode_e mode_q,
  output logic  restart_q,
  output logic  pin_q,
  output logic  vec_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= M_RUN;
      restart_q <= 1'b1;
      pin_q     <= mode_pin;
      vec_q     <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      restart_q <= restart_d;
      pin_q     <= pin_d;
      vec_q     <= vec_d;
    end
  end
endmodule

// File: rtl/opmode_pwr.sv
module opmode_pwr
  import opmode_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  mode_e   mode_q,
  input  logic    restart_q,
  output pwr_en_t en_q
);
  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= mode_enables(mode_q, restart_q);
  end
endmodule

// File: rtl/opmode_ctrl.sv
module opmode_ctrl
  import opmode_pkg::*;
#(
  parameter int              DEPTH_W  = 2,
  parameter int              VEC_W    = 16,
  parameter logic [VEC_W-1:0] VEC_ADDR = 16'hFFFE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dbg_force_rst,
  input  logic               mode_pin,
  input  logic               dbg_bg_cmd,
  input  logic               bg_instr,
  input  logic               brk_ctl_hit,
  input  logic               brk_mon_hit,
  input  logic               wait_instr,
  input  logic               stop_instr,
  input  logic [DEPTH_W-1:0] stop_depth,
  input  logic               wake,
  input  logic               dbg_go,
  output logic [2:0]         mode_o,
  output logic               cpu_clk_en,
  output logic               bus_clk_en,
  output logic               reg_full_en,
  output logic               ram_ret_en,
  output logic               regs_ret_en,
  output logic               vec_fetch,
  output logic [VEC_W-1:0]   vec_addr
);
  evt_t    ev;
  mode_e   mode_q, mode_d;
  logic    restart_q, restart_d, pin_q, pin_d, vec_q, vec_d;
  pwr_en_t en_q;

  assign ev = '{force_rst: dbg_force_rst, go: dbg_go, wake: wake,
                stop_i: stop_instr, wait_i: wait_instr, brk_mon: brk_mon_hit,
                brk_ctl: brk_ctl_hit, bg_instr: bg_instr, bg_cmd: dbg_bg_cmd};

  opmode_next #(.DEPTH_W(DEPTH_W)) u_next (
    .mode_q(mode_q), .restart_q(restart_q), .pin_q(pin_q), .mode_pin(mode_pin),
    .ev(ev), .stop_depth(stop_depth),
    .mode_d(mode_d), .restart_d(restart_d), .pin_d(pin_d), .vec_d(vec_d)
  );

  opmode_state u_state (
    .clk(clk), .rst(rst), .mode_pin(mode_pin),
    .mode_d(mode_d), .restart_d(restart_d), .pin_d(pin_d), .vec_d(vec_d),
    .mode_q(mode_q), .restart_q(restart_q), .pin_q(pin_q), .vec_q(vec_q)
  );

  opmode_pwr u_pwr (
    .clk(clk), .rst(rst), .mode_q(mode_q), .restart_q(restart_q), .en_q(en_q)
  );

  assign mode_o      = mode_q;
  assign cpu_clk_en  = en_q.cpu;
  assign bus_clk_en  = en_q.bus;
  assign reg_full_en = en_q.reg_full;
  assign ram_ret_en  = en_q.ram_ret;
  assign regs_ret_en = en_q.reg_ret;
  assign vec_fetch   = vec_q;
  assign vec_addr    = vec_q ? VEC_ADDR : '0;
endmodule

// File: rtl/opmode_ctrl_chk.sv
module opmode_ctrl_chk #(
  parameter int DEPTH_W = 2,
  parameter int VEC_W   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               dbg_force_rst,
  input logic               dbg_go,
  input logic               wait_instr,
  input logic               stop_instr,
  input logic [DEPTH_W-1:0] stop_depth,
  input logic [2:0]         mode_o,
  input logic               cpu_clk_en,
  input logic               bus_clk_en,
  input logic               reg_full_en,
  input logic               ram_ret_en,
  input logic               regs_ret_en,
  input logic               vec_fetch,
  input logic [VEC_W-1:0]   vec_addr
);
  // R2: vector strobe only in Run, one cycle wide, address non-zero
  assert_vec_in_run_R2: assert property (@(posedge clk) disable iff (rst)
    vec_fetch |-> (mode_o == 3'd0 && vec_addr != '0));
  assert_vec_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    vec_fetch |=> !vec_fetch);

  // R5: Background is left only by go or a forced reset
  assert_bkg_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd1 && !dbg_go && !dbg_force_rst && !$past(dbg_force_rst))
      |=> mode_o == 3'd1);

  // R6: settled Wait gates only the CPU clock
  assert_wait_en_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd2 && $past(mode_o) == 3'd2)
      |-> (!cpu_clk_en && bus_clk_en && reg_full_en));

  // R7: settled stop modes gate both clocks
  assert_stop_clk_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_o >= 3'd3 && mode_o <= 3'd5 && $past(mode_o) == mode_o)
      |-> (!cpu_clk_en && !bus_clk_en));

  // R8: settled stop depth 1 drops every retention
  assert_stop1_off_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd3 && $past(mode_o) == 3'd3)
      |-> (!reg_full_en && !ram_ret_en && !regs_ret_en));

  // R7: a stop with depth 0 in Run is ignored (no other strobe pending)
  assert_depth0_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd0 && stop_instr && stop_depth == '0 && !wait_instr
      && !dbg_force_rst && !vec_fetch && !$past(dbg_force_rst)
      && $past(mode_o) == 3'd0 && !$past(vec_fetch))
      |=> (mode_o == 3'd0 || mode_o == 3'd1));

  // R1: legal codes only
  assert_code_legal_R1: assert property (@(posedge clk) disable iff (rst)
    mode_o <= 3'd5);
endmodule

bind opmode_ctrl opmode_ctrl_chk #(.DEPTH_W(DEPTH_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .dbg_force_rst(dbg_force_rst), .dbg_go(dbg_go),
  .wait_instr(wait_instr), .stop_instr(stop_instr), .stop_depth(stop_depth),
  .mode_o(mode_o), .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en),
  .reg_full_en(reg_full_en), .ram_ret_en(ram_ret_en), .regs_ret_en(regs_ret_en),
  .vec_fetch(vec_fetch), .vec_addr(vec_addr)
);

// File: tb/tb_opmode_ctrl.sv
module tb_opmode_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_pin = 1'b1;
  logic [8:0]  ev = '0;  // 0 bgcmd 1 bginstr 2 brkctl 3 brkmon 4 wait 5 stop 6 wake 7 go 8 force
  logic [1:0]  stop_depth = '0;
  logic [2:0]  mode_o;
  logic        cpu_clk_en, bus_clk_en, reg_full_en, ram_ret_en, regs_ret_en, vec_fetch;
  logic [15:0] vec_addr;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  opmode_ctrl dut (
    .clk(clk), .rst(rst), .dbg_force_rst(ev[8]), .mode_pin(mode_pin),
    .dbg_bg_cmd(ev[0]), .bg_instr(ev[1]), .brk_ctl_hit(ev[2]), .brk_mon_hit(ev[3]),
    .wait_instr(ev[4]), .stop_instr(ev[5]), .stop_depth(stop_depth), .wake(ev[6]),
    .dbg_go(ev[7]), .mode_o(mode_o), .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en),
    .reg_full_en(reg_full_en), .ram_ret_en(ram_ret_en), .regs_ret_en(regs_ret_en),
    .vec_fetch(vec_fetch), .vec_addr(vec_addr)
  );

  logic [4:0] en_o;
  assign en_o = {cpu_clk_en, bus_clk_en, reg_full_en, ram_ret_en, regs_ret_en};

  // {cpu, bus, reg_full, ram, regs} from R6, R8, R11
  function automatic logic [4:0] exp_en(int m);
    case (m)
      0:       return 5'b11111;
      1, 2:    return 5'b01111;
      4:       return 5'b00010;
      5:       return 5'b00011;
      default: return 5'b00000;
    endcase
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(int idx);
    ev[idx] = 1'b1;
    tick();
    ev = '0;
  endtask

  initial begin
    repeat (3) tick();
    chk("R1 mode", mode_o, 0);
    chk("R1 enables", en_o, 0);
    chk("R1 vec", vec_fetch, 0);

    rst = 1'b0;
    tick();
    chk("R2 mode", mode_o, 0);
    chk("R2 vec", vec_fetch, 1);
    chk("R2 addr", vec_addr, 16'hFFFE);
    chk("R10 enables off after restart", en_o, 0);
    tick();
    chk("R2 vec single", vec_fetch, 0);
    chk("R2 addr idle", vec_addr, 0);
    chk("R11 run enables", en_o, exp_en(0));

    for (int i = 0; i < 4; i++) begin
      pulse(i);
      chk("R4 bg cause", mode_o, 1);
      chk("R11 enables lag", en_o, exp_en(0));
      tick();
      chk("R11 bkg enables", en_o, exp_en(1));
      for (int j = 0; j < 7; j++) begin
        stop_depth = 2'd3;
        pulse(j);
        chk("R5 ignored in bkg", mode_o, 1);
        chk("R5 bkg enables", en_o, exp_en(1));
      end
      pulse(7);
      chk("R5 go", mode_o, 0);
      chk("R5 go no vec", vec_fetch, 0);
      tick();
    end

    ev[1] = 1'b1; ev[4] = 1'b1; ev[5] = 1'b1; stop_depth = 2'd1;
    tick();
    ev = '0;
    chk("R4 priority", mode_o, 1);
    pulse(7);
    tick();

    pulse(4);
    chk("R6 wait", mode_o, 2);
    tick();
    chk("R6 wait enables", en_o, exp_en(2));
    stop_depth = 2'd3;
    pulse(5);
    chk("R9 stop in wait ignored", mode_o, 2);
    pulse(6);
    chk("R9 wake wait", mode_o, 0);
    chk("R9 no vec", vec_fetch, 0);
    tick();
    chk("R11 back to run", en_o, exp_en(0));
    pulse(6);
    chk("R9 wake in run ignored", mode_o, 0);

    stop_depth = 2'd0;
    pulse(5);
    chk("R7 depth0 ignored", mode_o, 0);
    tick();
    chk("R7 depth0 enables", en_o, exp_en(0));

    for (int d = 1; d <= 3; d++) begin
      stop_depth = 2'(d);
      pulse(5);
      chk("R7 stop code", mode_o, 2 + d);
      tick();
      chk("R8 stop enables", en_o, exp_en(2 + d));
      pulse(6);
      if (d == 3) begin
        chk("R9 wake stop3", mode_o, 0);
        chk("R9 stop3 no vec", vec_fetch, 0);
      end else begin
        chk("R10 restart holds code", mode_o, 2 + d);
        chk("R10 restart no vec yet", vec_fetch, 0);
        tick();
        chk("R10 run after restart", mode_o, 0);
        chk("R10 vec", vec_fetch, 1);
        chk("R10 enables off", en_o, 0);
      end
      tick();
      chk("R11 run enables after wake", en_o, exp_en(0));
    end

    mode_pin = 1'b0;
    stop_depth = 2'd1;
    pulse(5);
    tick();
    pulse(6);
    tick();
    chk("R10 pin low to bkg", mode_o, 1);
    chk("R10 pin low no vec", vec_fetch, 0);
    mode_pin = 1'b1;
    pulse(7);
    tick();

    mode_pin = 1'b0;
    pulse(8);
    mode_pin = 1'b1;
    chk("R3 force restart cycle", mode_o, 0);
    tick();
    chk("R3 force pin low", mode_o, 1);
    chk("R3 force no vec", vec_fetch, 0);
    pulse(8);
    tick();
    chk("R3 force pin high", mode_o, 0);
    chk("R3 force vec", vec_fetch, 1);
    tick();

    rst = 1'b1;
    mode_pin = 1'b0;
    tick();
    tick();
    chk("R1 mode in reset", mode_o, 0);
    rst = 1'b0;
    mode_pin = 1'b1;
    tick();
    chk("R3 reset pin low", mode_o, 1);
    chk("R3 reset no vec", vec_fetch, 0);
    tick();
    chk("R11 bkg enables after reset", en_o, exp_en(1));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule